// File: doc/BRIEF.md
# Dual-Axis Galvanometer Command Receiver

This block receives the serial command stream that steers a two-mirror scanner. Four wires come in: a bit clock, a frame marker and two data lines, one for each axis. The two data lines share the clock and the marker. The system clock oversamples all four wires and must run at least eight times faster than the bit clock. The block shifts one bit per axis on every falling edge of the bit clock. The marker stays high for the first nineteen bits of a frame and is low while the twentieth bit is on the wire, so a bit sampled with the marker low closes the frame.

A frame on each axis holds twenty bits. The first three are a control prefix, and the only value accepted is 0 then 0 then 1. Sixteen position bits follow, most significant first. The last bit is an even-parity bit. When a frame closes at exactly twenty bits, the block pulses `frame_valid` for one system clock and reports the control and parity result of each axis. It loads the two unsigned position words only when all four checks pass. A frame of the wrong length raises a one-cycle framing error and is thrown away.

The output is a plain strobe with no ready input. The serial link cannot be paused, so there is no back-pressure. The consumer must take the result in the cycle of `frame_valid`. The positions and flags then hold until the next complete frame.

Top module: `galvo_frame_rx`

## Requirements
- R1: While `rst_n` is low, and until the first frame is accepted, `frame_valid`, `framing_err`, both positions and all four check flags are 0.
- R2: After reset the receiver ignores all bits until it has sampled a bit with the marker low and then a bit with the marker high. The first frame after reset is therefore discarded without `frame_valid` or `framing_err`.
- R3: Bits are sampled on falling edges of the bit clock. Within a frame, the 4th to 19th bits form the position, with the 4th bit as bit 15 and the 19th bit as bit 0.
- R4: When the marker-low bit is the 20th bit since the frame began, `frame_valid` is high for exactly one system clock.
- R5: A control prefix other than 0,0,1 in the first three bits of an axis sets that axis's control-error flag with `frame_valid`. A correct prefix clears it.
- R6: The parity error of an axis is set when the XOR of all 20 received bits of that axis is 1, meaning the 20th bit does not make the count of ones even.
- R7: `x_pos` and `y_pos` change only in a `frame_valid` cycle in which all four check flags are 0. The flags are rewritten on every `frame_valid`.
- R8: A marker-low bit that closes a frame of fewer than 20 bits gives a one-cycle `framing_err`, no `frame_valid`, and no change to positions or flags.
- R9: A 20th bit sampled with the marker still high gives a one-cycle `framing_err` and restarts the bit count.
- R10: `frame_valid` and `framing_err` are never high in the same cycle.
- R11: The two axes are checked independently, so an error on one axis does not set the other axis's flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_in | input | 1 | Serial bit clock, asynchronous |
| mark_in | input | 1 | Frame marker, high for bits 1-19 |
| x_in | input | 1 | X-axis serial data |
| y_in | input | 1 | Y-axis serial data |
| frame_valid | output | 1 | One-cycle strobe for a complete 20-bit frame |
| x_pos | output | 16 | Last accepted X position |
| y_pos | output | 16 | Last accepted Y position |
| x_parity_err | output | 1 | Parity result of the X axis in the last frame |
| y_parity_err | output | 1 | Parity result of the Y axis in the last frame |
| x_ctrl_err | output | 1 | Control-prefix result of the X axis in the last frame |
| y_ctrl_err | output | 1 | Control-prefix result of the Y axis in the last frame |
| framing_err | output | 1 | One-cycle strobe for a frame of the wrong length |

## Verification
Several rules are checked by assertions on every cycle. The strobe lasts one clock and never coincides with a framing error. The positions move only in a clean `frame_valid` cycle. The bit counter never reaches twenty. No frame is reported before the receiver has armed. The bench scenarios are needed for the rest: the bit order and the position values, the prefix and parity decisions for each axis, the discarded first frame after reset, and the short and overlong frames that must produce a framing error and leave the stored positions alone.

// File: rtl/galvo_rx_pkg.sv
package galvo_rx_pkg;

  localparam int FRAME_BITS = 20;
  localparam int CTRL_BITS  = 3;
  localparam int POS_BITS   = FRAME_BITS - CTRL_BITS - 1;
  localparam int N_CHAN     = 2;
  localparam logic [CTRL_BITS-1:0] CTRL_EXPECT = 3'b001;

  typedef struct packed {
    logic                parity_err;
    logic                ctrl_err;
    logic [POS_BITS-1:0] pos;
  } chan_result_t;

  // Frame word: first received bit in the MSB.
  function automatic chan_result_t judge_frame(input logic [FRAME_BITS-1:0] f);
    chan_result_t r;
    r.ctrl_err   = (f[FRAME_BITS-1 -: CTRL_BITS] != CTRL_EXPECT);
    r.parity_err = ^f;
    r.pos        = f[POS_BITS:1];
    return r;
  endfunction

endpackage

// File: rtl/galvo_rx_input.sv
module galvo_rx_input #(
  parameter int N_LINES = 4,
  parameter int STAGES  = 2,
  parameter int CLK_IDX = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines_in,
  output logic [N_LINES-1:0] lines_s,
  output logic               clk_fall
);

  logic [N_LINES-1:0] stage_q [STAGES];
  logic               bclk_prev;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= lines_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign lines_s = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bclk_prev <= 1'b0;
    else        bclk_prev <= lines_s[CLK_IDX];

  assign clk_fall = bclk_prev & ~lines_s[CLK_IDX];

endmodule

// File: rtl/galvo_rx_shift.sv
module galvo_rx_shift #(
  parameter int N_CH       = 2,
  parameter int FRAME_BITS = 20,
  localparam int CW        = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample,
  input  logic                  mark_bit,
  input  logic [N_CH-1:0]       data_bits,
  output logic                  frame_done,
  output logic                  frame_bad,
  output logic [FRAME_BITS-1:0] frames [N_CH],
  output logic [CW-1:0]         bit_cnt,
  output logic                  armed
);

  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic low_seen;
  logic take_bit;

  // A bit is shifted once armed, or when it is the bit that arms.
  assign take_bit = sample & (armed | (low_seen & mark_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      low_seen   <= 1'b0;
      bit_cnt    <= '0;
      frame_done <= 1'b0;
      frame_bad  <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      frame_bad  <= 1'b0;
      if (sample) begin
        if (!armed) begin
          if (!mark_bit)     low_seen <= 1'b1;
          else if (low_seen) begin
            armed   <= 1'b1;
            bit_cnt <= CW'(1);
          end
        end else if (!mark_bit) begin
          if (bit_cnt == LAST) frame_done <= 1'b1;
          else                 frame_bad  <= 1'b1;
          bit_cnt <= '0;
        end else if (bit_cnt == LAST) begin
          frame_bad <= 1'b1;
          bit_cnt   <= '0;
        end else begin
          bit_cnt <= bit_cnt + CW'(1);
        end
      end
    end
  end

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)        frames[c] <= '0;
        else if (take_bit) frames[c] <= {frames[c][FRAME_BITS-2:0], data_bits[c]};
    end
  endgenerate

endmodule

// File: rtl/galvo_rx_check.sv
module galvo_rx_check
  import galvo_rx_pkg::*;
#(
  parameter int N_CH = N_CHAN
) (
  input  logic [FRAME_BITS-1:0] frames  [N_CH],
  output chan_result_t          results [N_CH]
);

  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_judge
      always_comb results[c] = judge_frame(frames[c]);
    end
  endgenerate

endmodule

// File: rtl/galvo_frame_rx.sv
module galvo_frame_rx
  import galvo_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_in,
  input  logic                mark_in,
  input  logic                x_in,
  input  logic                y_in,
  output logic                frame_valid,
  output logic [POS_BITS-1:0] x_pos,
  output logic [POS_BITS-1:0] y_pos,
  output logic                x_parity_err,
  output logic                y_parity_err,
  output logic                x_ctrl_err,
  output logic                y_ctrl_err,
  output logic                framing_err
);

  localparam int N_LINES = 2 + N_CHAN;
  localparam int CW      = $clog2(FRAME_BITS + 1);

  logic [N_LINES-1:0]    lines_s;
  logic                  clk_fall;
  logic                  frame_done;
  logic                  frame_bad;
  logic [FRAME_BITS-1:0] frames [N_CHAN];
  logic [CW-1:0]         bit_cnt;
  logic                  armed;
  chan_result_t          results [N_CHAN];
  logic                  all_clean;

  galvo_rx_input #(
    .N_LINES(N_LINES),
    .STAGES (SYNC_STAGES),
    .CLK_IDX(0)
  ) u_input (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines_in({y_in, x_in, mark_in, bclk_in}),
    .lines_s (lines_s),
    .clk_fall(clk_fall)
  );

  galvo_rx_shift #(
    .N_CH      (N_CHAN),
    .FRAME_BITS(FRAME_BITS)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample    (clk_fall),
    .mark_bit  (lines_s[1]),
    .data_bits (lines_s[N_LINES-1:2]),
    .frame_done(frame_done),
    .frame_bad (frame_bad),
    .frames    (frames),
    .bit_cnt   (bit_cnt),
    .armed     (armed)
  );

  galvo_rx_check #(.N_CH(N_CHAN)) u_check (
    .frames (frames),
    .results(results)
  );

  assign all_clean = !results[0].ctrl_err && !results[0].parity_err &&
                     !results[1].ctrl_err && !results[1].parity_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_valid  <= 1'b0;
      framing_err  <= 1'b0;
      x_pos        <= '0;
      y_pos        <= '0;
      x_parity_err <= 1'b0;
      y_parity_err <= 1'b0;
      x_ctrl_err   <= 1'b0;
      y_ctrl_err   <= 1'b0;
    end else begin
      frame_valid <= frame_done;
      framing_err <= frame_bad;
      if (frame_done) begin
        x_parity_err <= results[0].parity_err;
        x_ctrl_err   <= results[0].ctrl_err;
        y_parity_err <= results[1].parity_err;
        y_ctrl_err   <= results[1].ctrl_err;
        if (all_clean) begin
          x_pos <= results[0].pos;
          y_pos <= results[1].pos;
        end
      end
    end
  end

endmodule

// File: rtl/galvo_frame_rx_chk.sv
module galvo_frame_rx_chk #(
  parameter int PW = 16,
  parameter int CW = 5,
  parameter int FRAME_BITS = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_valid,
  input logic          framing_err,
  input logic [PW-1:0] x_pos,
  input logic [PW-1:0] y_pos,
  input logic          x_parity_err,
  input logic          y_parity_err,
  input logic          x_ctrl_err,
  input logic          y_ctrl_err,
  input logic [CW-1:0] bit_cnt,
  input logic          armed
);

  a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  a_r8_bad_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    framing_err |=> !framing_err);

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_valid && framing_err));

  a_r7_x_pos_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(x_pos) |-> (frame_valid && !x_parity_err && !y_parity_err &&
                         !x_ctrl_err && !y_ctrl_err));

  a_r7_y_pos_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(y_pos) |-> (frame_valid && !x_parity_err && !y_parity_err &&
                         !x_ctrl_err && !y_ctrl_err));

  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt < CW'(FRAME_BITS));

  a_r2_armed_first: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid || framing_err) |-> armed);

endmodule

bind galvo_frame_rx galvo_frame_rx_chk #(
  .PW(galvo_rx_pkg::POS_BITS),
  .CW($clog2(galvo_rx_pkg::FRAME_BITS + 1)),
  .FRAME_BITS(galvo_rx_pkg::FRAME_BITS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_valid (frame_valid),
  .framing_err (framing_err),
  .x_pos       (x_pos),
  .y_pos       (y_pos),
  .x_parity_err(x_parity_err),
  .y_parity_err(y_parity_err),
  .x_ctrl_err  (x_ctrl_err),
  .y_ctrl_err  (y_ctrl_err),
  .bit_cnt     (bit_cnt),
  .armed       (armed)
);

// File: tb/sim_galvo_frame_rx.sv
`timescale 1ns/1ps
module sim_galvo_frame_rx;

  localparam int HALF_BIT = 250;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk_in = 1'b0;
  logic        mark_in = 1'b0;
  logic        x_in = 1'b0;
  logic        y_in = 1'b0;
  logic        frame_valid;
  logic [15:0] x_pos;
  logic [15:0] y_pos;
  logic        x_parity_err;
  logic        y_parity_err;
  logic        x_ctrl_err;
  logic        y_ctrl_err;
  logic        framing_err;

  int n_checks = 0;
  int n_fail   = 0;
  int n_valid  = 0;
  int n_bad    = 0;

  always #2.5 clk = ~clk;

  galvo_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .mark_in(mark_in),
    .x_in(x_in), .y_in(y_in), .frame_valid(frame_valid),
    .x_pos(x_pos), .y_pos(y_pos),
    .x_parity_err(x_parity_err), .y_parity_err(y_parity_err),
    .x_ctrl_err(x_ctrl_err), .y_ctrl_err(y_ctrl_err),
    .framing_err(framing_err)
  );

  always @(posedge clk) begin
    if (rst_n && frame_valid) n_valid <= n_valid + 1;
    if (rst_n && framing_err) n_bad   <= n_bad + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] build(input logic [2:0] ctrl, input logic [15:0] d,
                                        input logic flip);
    logic p;
    p = ^{ctrl, d};
    return {ctrl, d, p ^ flip};
  endfunction

  // Sends nbits; the marker is low only on the last bit when last_low is set.
  task automatic send(input logic [19:0] fx, input logic [19:0] fy,
                      input int nbits, input logic last_low);
    @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      int idx;
      idx = (i < 20) ? 19 - i : 0;
      bclk_in = 1'b1;
      x_in    = fx[idx];
      y_in    = fy[idx];
      mark_in = !(last_low && i == nbits - 1);
      #HALF_BIT;
      bclk_in = 1'b0;
      #HALF_BIT;
    end
    mark_in = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 valid in reset", {31'd0, frame_valid}, 0);
    check("R1 pos in reset", {x_pos, y_pos}, 0);
    check("R1 flags in reset",
          {28'd0, x_parity_err, y_parity_err, x_ctrl_err, y_ctrl_err}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_first_discarded;
    int v0, b0;
    v0 = n_valid; b0 = n_bad;
    send(build(3'b001, 16'hAAAA, 0), build(3'b001, 16'h5555, 0), 20, 1);
    check("R2 no valid before arming", n_valid - v0, 0);
    check("R2 no framing error before arming", n_bad - b0, 0);
    check("R1 pos untouched after first frame", {x_pos, y_pos}, 0);
  endtask

  task automatic t_good(input logic [15:0] xd, input logic [15:0] yd, input string tag);
    int v0, b0;
    v0 = n_valid; b0 = n_bad;
    send(build(3'b001, xd, 0), build(3'b001, yd, 0), 20, 1);
    check({"R4 one strobe ", tag}, n_valid - v0, 1);
    check({"R10 no framing error ", tag}, n_bad - b0, 0);
    check({"R3 x_pos ", tag}, {16'd0, x_pos}, {16'd0, xd});
    check({"R3 y_pos ", tag}, {16'd0, y_pos}, {16'd0, yd});
    check({"R7 flags clear ", tag},
          {28'd0, x_parity_err, y_parity_err, x_ctrl_err, y_ctrl_err}, 0);
  endtask

  task automatic t_parity_x;
    logic [15:0] xp, yp;
    int v0;
    xp = x_pos; yp = y_pos; v0 = n_valid;
    send(build(3'b001, 16'h0F0F, 1), build(3'b001, 16'h7001, 0), 20, 1);
    check("R6 strobe on parity error", n_valid - v0, 1);
    check("R6 x parity flag", {31'd0, x_parity_err}, 1);
    check("R11 y parity untouched", {31'd0, y_parity_err}, 0);
    check("R7 pos held on parity error", {x_pos, y_pos}, {xp, yp});
  endtask

  task automatic t_ctrl_y;
    logic [15:0] xp, yp;
    xp = x_pos; yp = y_pos;
    send(build(3'b001, 16'h1111, 0), build(3'b011, 16'h2222, 0), 20, 1);
    check("R5 y ctrl flag", {31'd0, y_ctrl_err}, 1);
    check("R11 x ctrl clear", {31'd0, x_ctrl_err}, 0);
    check("R6 no parity flag with good parity", {30'd0, x_parity_err, y_parity_err}, 0);
    check("R7 pos held on ctrl error", {x_pos, y_pos}, {xp, yp});
  endtask

  task automatic t_short;
    logic [15:0] xp, yp;
    logic [3:0]  fl;
    int v0, b0;
    xp = x_pos; yp = y_pos; v0 = n_valid; b0 = n_bad;
    fl = {x_parity_err, y_parity_err, x_ctrl_err, y_ctrl_err};
    send(build(3'b001, 16'h9999, 0), build(3'b001, 16'h6666, 0), 15, 1);
    check("R8 framing error on short frame", n_bad - b0, 1);
    check("R8 no strobe on short frame", n_valid - v0, 0);
    check("R8 pos held", {x_pos, y_pos}, {xp, yp});
    check("R8 flags held", {28'd0, x_parity_err, y_parity_err, x_ctrl_err, y_ctrl_err},
          {28'd0, fl});
  endtask

  task automatic t_long;
    logic [15:0] xp, yp;
    int v0, b0;
    xp = x_pos; yp = y_pos; v0 = n_valid; b0 = n_bad;
    // 20 bits with the marker high, then one closing bit (a 1-bit frame).
    send(build(3'b001, 16'h4321, 0), build(3'b001, 16'h8765, 0), 21, 1);
    check("R9 framing errors on overlong frame", n_bad - b0, 2);
    check("R9 no strobe on overlong frame", n_valid - v0, 0);
    check("R9 pos held", {x_pos, y_pos}, {xp, yp});
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    t_first_discarded();
    t_good(16'h1234, 16'hBEEF, "mixed");
    t_good(16'h0000, 16'hFFFF, "extremes");
    t_good(16'h8001, 16'h0001, "edges");
    t_parity_x();
    t_ctrl_y();
    t_short();
    t_good(16'hC3A5, 16'h5A3C, "recovery");
    t_long();
    t_good(16'h0F00, 16'h00F0, "after overlong");
    do_reset();
    t_first_discarded();
    t_good(16'h7777, 16'h1357, "after second reset");
    finish_run();
  end

endmodule